// File: doc/BRIEF.md
# Maskable Interrupt Status Controller

This block gathers the interrupt-capable status of a token-passing network controller into one registered interrupt line. Five sources feed it. Two are live levels from the protocol engine: the receiver being inhibited and the transmitter being available. Three are single-cycle event pulses: a reconfiguration timeout, an excessive negative-acknowledge condition and the discovery of a new successor node ID. Each pulse event is latched in a sticky flag until its own clearing action occurs.

The host writes an 8-bit mask in which each bit lines up with the status bit it gates. The interrupt is the OR of every status bit ANDed with its mask bit. Each sticky source has its own clearing rule. The reconfiguration flag clears on a general "clear flags" strobe. The excessive-NAK flag clears only on a separate power-on-style clear strobe. The new-successor flag clears when the host reads the successor ID register. The two level sources are never latched. Masking them hides the interrupt, and unmasking brings it back while the condition is still present.

Top module: `irq_mask_ctrl`

## Requirements
- R1: The status word has the transmitter-available level at bit 0, the receiver-inhibited level at bit 1, the reconfiguration flag at bit 2, the excessive-NAK flag at bit 3 and the new-successor flag at bit 4. Bits 7:5 always read 0 and no other input reaches the interrupt.
- R2: While `rst_n` is low, `mask_o` reads 0x00 and `irq_o` is 0, whatever the source inputs are.
- R3: A cycle with `mask_we_i` high loads `mask_wdata_i[4:0]` into the mask, visible on `mask_o` after that clock edge. Ones written to bits 7:5 are dropped: they read back 0 and cannot enable an interrupt.
- R4: `irq_o` equals, one clock later, the OR over all bits of `status_o & mask_o` as it stood before the edge.
- R5: Bits 0 and 1 of the status follow `tx_avail_i` and `rx_inhibit_i` in the same cycle. Clearing their mask bit suppresses the interrupt without clearing anything, and setting it again while the level is still high brings the interrupt back.
- R6: A `recon_evt_i` pulse sets status bit 2. The bit holds until a cycle with `clr_flags_i` high, and `por_clr_flags_i` and `nextid_rd_i` leave it unchanged.
- R7: An `excnak_evt_i` pulse sets status bit 3. The bit holds until a cycle with `por_clr_flags_i` high, and `clr_flags_i` and `nextid_rd_i` leave it unchanged.
- R8: A `newid_evt_i` pulse sets status bit 4. The bit holds until a cycle with `nextid_rd_i` high, and both clear strobes leave it unchanged.
- R9: When an event pulse and its own clearing strobe occur in the same cycle, the flag ends up set.
- R10: Reset clears all three sticky flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_inhibit_i | input | 1 | Receiver-inhibited level |
| tx_avail_i | input | 1 | Transmitter-available level |
| recon_evt_i | input | 1 | Reconfiguration-timeout event pulse |
| excnak_evt_i | input | 1 | Excessive-NAK event pulse |
| newid_evt_i | input | 1 | New-successor-ID event pulse |
| mask_we_i | input | 1 | Mask write strobe |
| mask_wdata_i | input | 8 | Mask write data |
| clr_flags_i | input | 1 | General clear-flags strobe |
| por_clr_flags_i | input | 1 | Power-on-style clear-flags strobe |
| nextid_rd_i | input | 1 | Successor ID register read strobe |
| mask_o | output | 8 | Current mask |
| status_o | output | 8 | Current status word |
| irq_o | output | 1 | Registered interrupt, active high |

## Verification
Directed sequences set each sticky flag and then apply every strobe in turn. Only the flag's own strobe may clear it, which would expose swapped clear wiring. Mask-then-unmask on a held level tells a pass-through source apart from a latched one. A pulse given together with its clear in the same cycle shows which of the two wins. Writing 0xFF to the mask checks that the undefined bits are dropped. A long run of random levels, pulses, strobes and mask writes then compares mask, status and interrupt every cycle against a bench model, and this catches errors in latency and gating.

// File: rtl/irq_pkg.sv
package irq_pkg;
   // sticky flag slots inside the controller
   localparam int N_STICKY   = 3;
   localparam int STK_RECON  = 0;
   localparam int STK_EXCNAK = 1;
   localparam int STK_NEWID  = 2;
   // number of interrupt-capable sources
   localparam int N_SRC      = 5;
endpackage

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
   parameter int                W        = 8,
   parameter logic [W-1:0]      KEEP     = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         we,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (we) q <= wdata & KEEP;
   end
endmodule

// File: rtl/irq_sticky.sv
module irq_sticky (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic q
);
   // a new event outranks a clear in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= 1'b0;
      else if (set) q <= 1'b1;
      else if (clr) q <= 1'b0;
   end
endmodule

// File: rtl/irq_out_reg.sv
module irq_out_reg #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] status,
   input  logic [W-1:0] mask,
   output logic         irq
);
   logic hit;
   assign hit = |(status & mask);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq <= 1'b0;
      else        irq <= hit;
   end
endmodule

// File: rtl/irq_mask_ctrl.sv
module irq_mask_ctrl
   import irq_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int POS_TA     = 0,
   parameter int POS_RI     = 1,
   parameter int POS_RECON  = 2,
   parameter int POS_EXCNAK = 3,
   parameter int POS_NEWID  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_inhibit_i,
   input  logic              tx_avail_i,
   input  logic              recon_evt_i,
   input  logic              excnak_evt_i,
   input  logic              newid_evt_i,
   input  logic              mask_we_i,
   input  logic [DATA_W-1:0] mask_wdata_i,
   input  logic              clr_flags_i,
   input  logic              por_clr_flags_i,
   input  logic              nextid_rd_i,
   output logic [DATA_W-1:0] mask_o,
   output logic [DATA_W-1:0] status_o,
   output logic              irq_o
);
   localparam logic [DATA_W-1:0] ONE      = 1;
   localparam logic [DATA_W-1:0] DEF_BITS = (ONE << POS_TA) | (ONE << POS_RI)
                                          | (ONE << POS_RECON) | (ONE << POS_EXCNAK)
                                          | (ONE << POS_NEWID);

   // elaboration-time parameter checks
   if (DATA_W < N_SRC) begin : g_bad_width
      $error("irq_mask_ctrl: DATA_W too small for all sources");
   end
   if (POS_TA >= DATA_W || POS_RI >= DATA_W || POS_RECON >= DATA_W
       || POS_EXCNAK >= DATA_W || POS_NEWID >= DATA_W) begin : g_bad_pos
      $error("irq_mask_ctrl: source position outside data word");
   end
   if ($countones(DEF_BITS) != N_SRC) begin : g_dup_pos
      $error("irq_mask_ctrl: source positions overlap");
   end

   // mask register, undefined bits forced to zero
   irq_mask_reg #(.W(DATA_W), .KEEP(DEF_BITS)) u_mask (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (mask_we_i),
      .wdata (mask_wdata_i),
      .q     (mask_o)
   );

   // sticky event flags, each with its own clear source
   logic [N_STICKY-1:0] stk_set, stk_clr, stk_q;
   always_comb begin
      stk_set             = '0;
      stk_clr             = '0;
      stk_set[STK_RECON]  = recon_evt_i;
      stk_clr[STK_RECON]  = clr_flags_i;
      stk_set[STK_EXCNAK] = excnak_evt_i;
      stk_clr[STK_EXCNAK] = por_clr_flags_i;
      stk_set[STK_NEWID]  = newid_evt_i;
      stk_clr[STK_NEWID]  = nextid_rd_i;
   end

   for (genvar i = 0; i < N_STICKY; i++) begin : g_stk
      irq_sticky u_flag (
         .clk   (clk),
         .rst_n (rst_n),
         .set   (stk_set[i]),
         .clr   (stk_clr[i]),
         .q     (stk_q[i])
      );
   end

   // status word: live levels plus sticky flags
   always_comb begin
      status_o             = '0;
      status_o[POS_TA]     = tx_avail_i;
      status_o[POS_RI]     = rx_inhibit_i;
      status_o[POS_RECON]  = stk_q[STK_RECON];
      status_o[POS_EXCNAK] = stk_q[STK_EXCNAK];
      status_o[POS_NEWID]  = stk_q[STK_NEWID];
   end

   irq_out_reg #(.W(DATA_W)) u_irq (
      .clk    (clk),
      .rst_n  (rst_n),
      .status (status_o),
      .mask   (mask_o),
      .irq    (irq_o)
   );
endmodule

// File: rtl/irq_mask_ctrl_chk.sv
module irq_mask_ctrl_chk #(
   parameter int DATA_W     = 8,
   parameter int POS_TA     = 0,
   parameter int POS_RI     = 1,
   parameter int POS_RECON  = 2,
   parameter int POS_EXCNAK = 3,
   parameter int POS_NEWID  = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rx_inhibit_i,
   input logic              tx_avail_i,
   input logic              recon_evt_i,
   input logic              excnak_evt_i,
   input logic              newid_evt_i,
   input logic              mask_we_i,
   input logic [DATA_W-1:0] mask_wdata_i,
   input logic              clr_flags_i,
   input logic              por_clr_flags_i,
   input logic              nextid_rd_i,
   input logic [DATA_W-1:0] mask_o,
   input logic [DATA_W-1:0] status_o,
   input logic              irq_o
);
   localparam logic [DATA_W-1:0] ONE      = 1;
   localparam logic [DATA_W-1:0] DEF_BITS = (ONE << POS_TA) | (ONE << POS_RI)
                                          | (ONE << POS_RECON) | (ONE << POS_EXCNAK)
                                          | (ONE << POS_NEWID);

   // R1
   undef_status_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (status_o & ~DEF_BITS) == '0);

   // R3
   undef_mask_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_o & ~DEF_BITS) == '0);

   // R3
   mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mask_we_i |=> mask_o == ($past(mask_wdata_i) & DEF_BITS));

   // R4
   irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> irq_o == $past(|(status_o & mask_o)));

   // R5
   level_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      status_o[POS_TA] == tx_avail_i && status_o[POS_RI] == rx_inhibit_i);

   // R6
   recon_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_flags_i && !recon_evt_i) |=> $stable(status_o[POS_RECON]));

   // R7
   excnak_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!por_clr_flags_i && !excnak_evt_i) |=> $stable(status_o[POS_EXCNAK]));

   // R8
   newid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!nextid_rd_i && !newid_evt_i) |=> $stable(status_o[POS_NEWID]));

   // R9
   set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (recon_evt_i || excnak_evt_i || newid_evt_i) |=>
         ((!$past(recon_evt_i)  || status_o[POS_RECON])
       && (!$past(excnak_evt_i) || status_o[POS_EXCNAK])
       && (!$past(newid_evt_i)  || status_o[POS_NEWID])));

   // R2
   always @(negedge clk) begin
      if (!rst_n) begin
         reset_quiet_chk: assert (irq_o == 1'b0 && mask_o == '0);
      end
   end
endmodule

bind irq_mask_ctrl irq_mask_ctrl_chk #(
   .DATA_W(DATA_W), .POS_TA(POS_TA), .POS_RI(POS_RI), .POS_RECON(POS_RECON),
   .POS_EXCNAK(POS_EXCNAK), .POS_NEWID(POS_NEWID)
) u_chk (
   .clk(clk), .rst_n(rst_n), .rx_inhibit_i(rx_inhibit_i), .tx_avail_i(tx_avail_i),
   .recon_evt_i(recon_evt_i), .excnak_evt_i(excnak_evt_i), .newid_evt_i(newid_evt_i),
   .mask_we_i(mask_we_i), .mask_wdata_i(mask_wdata_i), .clr_flags_i(clr_flags_i),
   .por_clr_flags_i(por_clr_flags_i), .nextid_rd_i(nextid_rd_i),
   .mask_o(mask_o), .status_o(status_o), .irq_o(irq_o)
);

// File: tb/irq_mask_ctrl_bench.sv
module irq_mask_ctrl_bench;
   logic       clk = 1'b0;
   logic       rst_n;
   logic       ri, ta, ev_rc, ev_xn, ev_ni, we, clr, por, nrd;
   logic [7:0] wdata;
   logic [7:0] mask_o, status_o;
   logic       irq_o;

   always #2.5 clk = ~clk;

   irq_mask_ctrl u_irq_mask_ctrl (
      .clk(clk), .rst_n(rst_n), .rx_inhibit_i(ri), .tx_avail_i(ta),
      .recon_evt_i(ev_rc), .excnak_evt_i(ev_xn), .newid_evt_i(ev_ni),
      .mask_we_i(we), .mask_wdata_i(wdata), .clr_flags_i(clr),
      .por_clr_flags_i(por), .nextid_rd_i(nrd),
      .mask_o(mask_o), .status_o(status_o), .irq_o(irq_o)
   );

   int   n_chk = 0, n_bad = 0;
   bit   done = 0;
   // model state
   logic [7:0] m_mask;
   logic       m_rc, m_xn, m_ni, m_irq;

   function automatic logic [7:0] m_status();
      return {3'b000, m_ni, m_xn, m_rc, ri, ta};
   endfunction

   task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic idle();
      ev_rc = 0; ev_xn = 0; ev_ni = 0; we = 0; clr = 0; por = 0; nrd = 0;
   endtask

   // one clock: model follows the edge, then sample at the falling edge
   task automatic tick();
      logic nirq;
      @(posedge clk);
      nirq = |(m_status() & m_mask);
      if (we) m_mask = wdata & 8'h1F;
      m_rc = ev_rc ? 1'b1 : (clr ? 1'b0 : m_rc);
      m_xn = ev_xn ? 1'b1 : (por ? 1'b0 : m_xn);
      m_ni = ev_ni ? 1'b1 : (nrd ? 1'b0 : m_ni);
      m_irq = nirq;
      @(negedge clk);
   endtask

   task automatic cmp_all(string tag);
      chk({tag, " R3 mask"},   mask_o,   m_mask);
      chk({tag, " R1 status"}, status_o, m_status());
      chk({tag, " R4 irq"},    {7'b0, irq_o}, {7'b0, m_irq});
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++; n_chk++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4242));
      rst_n = 0; ri = 1; ta = 1; wdata = 8'hFF; idle();
      we = 1;
      m_mask = 0; m_rc = 0; m_xn = 0; m_ni = 0; m_irq = 0;
      repeat (3) @(negedge clk);
      // R2 reset state despite active inputs and mask write
      chk("R2 mask in reset", mask_o, 8'h00);
      chk("R2 irq in reset", {7'b0, irq_o}, 8'h00);
      // R10 sticky flags clear
      chk("R10 sticky in reset", status_o & 8'h1C, 8'h00);
      idle(); ri = 0; ta = 0;
      rst_n = 1;
      @(negedge clk);

      // R3 undefined bits dropped
      we = 1; wdata = 8'hFF; tick(); idle();
      chk("R3 write FF", mask_o, 8'h1F);
      tick(); chk("R4 no source irq", {7'b0, irq_o}, 8'h00);

      // R5 mask/unmask on held TA level
      ta = 1; tick(); tick();
      chk("R5 TA irq", {7'b0, irq_o}, 8'h01);
      we = 1; wdata = 8'h1E; tick(); idle(); tick();
      chk("R5 TA masked", {7'b0, irq_o}, 8'h00);
      chk("R5 TA still live", status_o & 8'h01, 8'h01);
      we = 1; wdata = 8'h1F; tick(); idle(); tick();
      chk("R5 TA reappears", {7'b0, irq_o}, 8'h01);
      ta = 0; we = 1; wdata = 8'h00; tick(); idle();

      // R6..R8 each flag cleared only by its own strobe
      ev_rc = 1; ev_xn = 1; ev_ni = 1; tick(); idle();
      chk("R6 R7 R8 all set", status_o & 8'h1C, 8'h1C);
      por = 1; nrd = 1; tick(); idle();
      chk("R6 recon kept", status_o & 8'h04, 8'h04);
      clr = 1; tick(); idle();
      chk("R6 recon cleared", status_o & 8'h04, 8'h00);
      chk("R8 newid cleared by read", status_o & 8'h10, 8'h00);
      chk("R7 excnak cleared by por", status_o & 8'h08, 8'h00);
      ev_xn = 1; tick(); idle(); clr = 1; nrd = 1; tick(); idle();
      chk("R7 excnak kept", status_o & 8'h08, 8'h08);
      ev_ni = 1; tick(); idle(); clr = 1; por = 1; tick(); idle();
      chk("R8 newid kept", status_o & 8'h18, 8'h10);
      por = 1; nrd = 1; tick(); idle();

      // R9 set wins over same-cycle clear
      ev_rc = 1; clr = 1; ev_xn = 1; por = 1; ev_ni = 1; nrd = 1; tick(); idle();
      chk("R9 set wins", status_o & 8'h1C, 8'h1C);
      // R1 RI at bit 1 gates interrupt via mask bit 1 only
      clr = 1; por = 1; nrd = 1; ri = 1; we = 1; wdata = 8'h02; tick(); idle(); tick();
      chk("R1 RI position", {7'b0, irq_o}, 8'h01);
      ri = 0; tick();

      // random phase
      for (int k = 0; k < 3000; k++) begin
         if ($urandom_range(7) == 0) ri = ~ri;
         if ($urandom_range(7) == 0) ta = ~ta;
         ev_rc = ($urandom_range(9) == 0);
         ev_xn = ($urandom_range(9) == 0);
         ev_ni = ($urandom_range(9) == 0);
         clr   = ($urandom_range(7) == 0);
         por   = ($urandom_range(7) == 0);
         nrd   = ($urandom_range(7) == 0);
         we    = ($urandom_range(5) == 0);
         wdata = 8'($urandom);
         tick();
         cmp_all("rand");
      end
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule